// File: doc/BRIEF.md
# Macro-op to Micro-op Cracker

This block takes one decoded complex instruction at a time and expands it into a short, ordered run of simple micro-ops. Each micro-op goes out over a valid/ready channel, one per cycle. The incoming instruction carries a class code, an ALU function, destination and source register numbers, a memory base register with a displacement, and an immediate. Each outgoing micro-op carries an operation code, a function field, a destination, two sources and an immediate. A last flag marks the final micro-op of each instruction.

The length and order of each expansion depend only on the class. Register-only work takes one micro-op. Work that touches memory gets separate load and store steps around the ALU step. Call, return and push become short stack sequences. Values that pass between micro-ops of one instruction go through a temporary register that software cannot see. The stack pointer and the temporary register sit at fixed register numbers chosen by parameter. A new instruction is taken only when the previous one has been fully sent. It may also be taken in the same cycle that its final micro-op is accepted, so no idle cycle appears between instructions.

Top module: `uc_cracker`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Class 0 (register ALU) emits one micro-op: op 1, fn = in_fn, dst = in_dst, srca = in_dst, srcb = in_src, imm 0. Class 1 (compare) emits one micro-op: op 2, fn 0, dst 0, srca = in_dst, srcb = in_src, imm 0. Class 2 (branch) emits one micro-op: op 3, fn = in_fn (the condition), registers 0, imm = in_imm.
- R3: Class 3 (load) emits one micro-op: op 4, dst = in_dst, srca = in_base, srcb 0, imm = in_disp. Class 4 (store) emits one micro-op: op 5, dst 0, srca = in_base, srcb = in_src, imm = in_disp. Both have fn 0.
- R4: Class 5 (ALU with a memory source) emits two micro-ops. First a load (op 4) of the temporary register from in_base + in_disp. Then an ALU op (op 1, fn = in_fn) with dst = in_dst, srca = in_dst, srcb = temporary.
- R5: Class 6 (ALU with a memory destination) emits three micro-ops. First a load of the temporary register from in_base + in_disp. Then an ALU op with dst = temporary, srca = temporary, srcb = in_src. Then a store (op 5) of the temporary register, with srcb = temporary, back to in_base + in_disp.
- R6: Class 7 (call) emits four micro-ops, in this order:
  - op 7: read PC into the temporary register;
  - op 5: store the temporary register to stack pointer + (-4);
  - op 6: add -4 to the stack pointer (dst = srca = stack pointer);
  - op 8: jump with imm = in_imm.
- R7: Class 8 (return) emits three micro-ops, in this order:
  - op 6: add +4 to the stack pointer;
  - op 4: load the temporary register from stack pointer + (-4);
  - op 9: jump through a register, with srca = temporary.
- R8: Class 9 (push) emits two micro-ops: a store (op 5) of in_src to stack pointer + (-4), then an add of -4 to the stack pointer (op 6).
- R9: While `out_valid` is 1 and `out_ready` is 0, every micro-op output holds its value. The sequence moves forward only on a valid-and-ready handshake.
- R10: `in_ready` is 1 only when no micro-op is pending, or when the final micro-op is being accepted in that cycle. An instruction accepted in that same cycle shows its first micro-op in the next cycle.
- R11: Class codes 10 to 15 emit a single no-op micro-op (op 0, all fields 0) with last set.
- R12: `out_last` is 1 on the final micro-op of each expansion and 0 on all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken this cycle if valid |
| in_cls | input | 4 | Instruction class code |
| in_fn | input | FN_W | ALU function or branch condition |
| in_dst | input | REG_W | Destination register |
| in_src | input | REG_W | Source register |
| in_base | input | REG_W | Memory base register |
| in_disp | input | IMM_W | Memory displacement |
| in_imm | input | IMM_W | Immediate or jump target |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_op | output | 4 | Micro-op operation code |
| out_fn | output | FN_W | Micro-op function field |
| out_dst | output | REG_W | Micro-op destination register |
| out_srca | output | REG_W | Micro-op first source register |
| out_srcb | output | REG_W | Micro-op second source register |
| out_imm | output | IMM_W | Micro-op immediate |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The bench builds the cracker with 5-bit register numbers, a 16-bit immediate and a 3-bit function field. The stack pointer is register 29 and the temporary is register 31, so both fixed registers differ from the small random numbers in the instruction fields and show up clearly in every stack and memory sequence. The 16-bit immediate makes the -4 and +4 stack offsets easy to tell apart from random displacements. Random backpressure and random offer gaps exercise stalls at every step of the four-step call sequence and at back-to-back instruction handover.

// File: rtl/uc_pkg.sv
package uc_pkg;

    localparam int MAX_UOPS = 4;

    typedef enum logic [3:0] {
        CLS_ALU    = 4'd0,
        CLS_CMP    = 4'd1,
        CLS_BR     = 4'd2,
        CLS_LD     = 4'd3,
        CLS_ST     = 4'd4,
        CLS_ALU_MS = 4'd5,
        CLS_ALU_MD = 4'd6,
        CLS_CALL   = 4'd7,
        CLS_RET    = 4'd8,
        CLS_PUSH   = 4'd9
    } icls_e;

    typedef enum logic [3:0] {
        UOP_NOP  = 4'd0,
        UOP_ALU  = 4'd1,
        UOP_CMP  = 4'd2,
        UOP_BR   = 4'd3,
        UOP_LD   = 4'd4,
        UOP_ST   = 4'd5,
        UOP_ADDI = 4'd6,
        UOP_RDPC = 4'd7,
        UOP_JMP  = 4'd8,
        UOP_JMPR = 4'd9
    } uop_e;

    typedef enum logic [2:0] {
        SEL_ZERO, SEL_DST, SEL_SRC, SEL_BASE, SEL_SP, SEL_TMP
    } rsel_e;

    typedef enum logic [2:0] {
        IMM_ZERO, IMM_DISP, IMM_IMM, IMM_M4, IMM_P4
    } isel_e;

    typedef struct packed {
        uop_e  op;
        logic  use_fn;
        rsel_e dst;
        rsel_e sa;
        rsel_e sb;
        isel_e imm;
    } uop_tpl_t;

    // Number of micro-ops each class expands into.
    function automatic logic [2:0] seq_len(logic [3:0] cls);
        case (cls)
            CLS_ALU_MS, CLS_PUSH: return 3'd2;
            CLS_ALU_MD, CLS_RET:  return 3'd3;
            CLS_CALL:             return 3'd4;
            default:              return 3'd1;
        endcase
    endfunction

    function automatic uop_tpl_t mk_tpl(uop_e op, logic fn, rsel_e d, rsel_e a, rsel_e b, isel_e i);
        uop_tpl_t t;
        t.op = op; t.use_fn = fn; t.dst = d; t.sa = a; t.sb = b; t.imm = i;
        return t;
    endfunction

    // Shape of micro-op number 'step' of a class, in symbolic selectors.
    function automatic uop_tpl_t uop_template(logic [3:0] cls, logic [1:0] step);
        uop_tpl_t nop;
        nop = mk_tpl(UOP_NOP, 1'b0, SEL_ZERO, SEL_ZERO, SEL_ZERO, IMM_ZERO);
        case (cls)
            CLS_ALU: return mk_tpl(UOP_ALU, 1'b1, SEL_DST, SEL_DST, SEL_SRC, IMM_ZERO);
            CLS_CMP: return mk_tpl(UOP_CMP, 1'b0, SEL_ZERO, SEL_DST, SEL_SRC, IMM_ZERO);
            CLS_BR:  return mk_tpl(UOP_BR, 1'b1, SEL_ZERO, SEL_ZERO, SEL_ZERO, IMM_IMM);
            CLS_LD:  return mk_tpl(UOP_LD, 1'b0, SEL_DST, SEL_BASE, SEL_ZERO, IMM_DISP);
            CLS_ST:  return mk_tpl(UOP_ST, 1'b0, SEL_ZERO, SEL_BASE, SEL_SRC, IMM_DISP);
            CLS_ALU_MS:
                if (step == 2'd0) return mk_tpl(UOP_LD, 1'b0, SEL_TMP, SEL_BASE, SEL_ZERO, IMM_DISP);
                else              return mk_tpl(UOP_ALU, 1'b1, SEL_DST, SEL_DST, SEL_TMP, IMM_ZERO);
            CLS_ALU_MD:
                case (step)
                    2'd0:    return mk_tpl(UOP_LD, 1'b0, SEL_TMP, SEL_BASE, SEL_ZERO, IMM_DISP);
                    2'd1:    return mk_tpl(UOP_ALU, 1'b1, SEL_TMP, SEL_TMP, SEL_SRC, IMM_ZERO);
                    default: return mk_tpl(UOP_ST, 1'b0, SEL_ZERO, SEL_BASE, SEL_TMP, IMM_DISP);
                endcase
            CLS_CALL:
                case (step)
                    2'd0:    return mk_tpl(UOP_RDPC, 1'b0, SEL_TMP, SEL_ZERO, SEL_ZERO, IMM_ZERO);
                    2'd1:    return mk_tpl(UOP_ST, 1'b0, SEL_ZERO, SEL_SP, SEL_TMP, IMM_M4);
                    2'd2:    return mk_tpl(UOP_ADDI, 1'b0, SEL_SP, SEL_SP, SEL_ZERO, IMM_M4);
                    default: return mk_tpl(UOP_JMP, 1'b0, SEL_ZERO, SEL_ZERO, SEL_ZERO, IMM_IMM);
                endcase
            CLS_RET:
                case (step)
                    2'd0:    return mk_tpl(UOP_ADDI, 1'b0, SEL_SP, SEL_SP, SEL_ZERO, IMM_P4);
                    2'd1:    return mk_tpl(UOP_LD, 1'b0, SEL_TMP, SEL_SP, SEL_ZERO, IMM_M4);
                    default: return mk_tpl(UOP_JMPR, 1'b0, SEL_ZERO, SEL_TMP, SEL_ZERO, IMM_ZERO);
                endcase
            CLS_PUSH:
                if (step == 2'd0) return mk_tpl(UOP_ST, 1'b0, SEL_ZERO, SEL_SP, SEL_SRC, IMM_M4);
                else              return mk_tpl(UOP_ADDI, 1'b0, SEL_SP, SEL_SP, SEL_ZERO, IMM_M4);
            default: return nop;
        endcase
    endfunction

endpackage

// File: rtl/uc_step_ctrl.sv
module uc_step_ctrl #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic [STEP_W:0]   seq_len,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              last,
    output logic              in_ready,
    output logic              accept
);
    logic hs;

    assign hs       = busy & out_ready;
    assign last     = busy & ({1'b0, step} == (seq_len - 1'b1));
    assign in_ready = ~busy | (hs & last);
    assign accept   = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            step <= '0;
        end else if (hs && last) begin
            busy <= 1'b0;
            step <= '0;
        end else if (hs) begin
            step <= step + 1'b1;
        end
    end

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && !out_ready |=> busy && $stable(step)); // R9

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, step} < seq_len)); // R12

endmodule

// File: rtl/uc_uop_gen.sv
module uc_uop_gen
    import uc_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int IMM_W   = 16,
    parameter int FN_W    = 3,
    parameter int SP_IDX  = 14,
    parameter int TMP_IDX = 15,
    parameter int STEP_W  = 2
) (
    input  logic [3:0]        cls,
    input  logic [STEP_W-1:0] step,
    input  logic [FN_W-1:0]   fn_i,
    input  logic [REG_W-1:0]  dst_i,
    input  logic [REG_W-1:0]  src_i,
    input  logic [REG_W-1:0]  base_i,
    input  logic [IMM_W-1:0]  disp_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [3:0]        op_o,
    output logic [FN_W-1:0]   fn_o,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  sa_o,
    output logic [REG_W-1:0]  sb_o,
    output logic [IMM_W-1:0]  imm_o
);
    localparam logic [REG_W-1:0] SP_R  = REG_W'(SP_IDX);
    localparam logic [REG_W-1:0] TMP_R = REG_W'(TMP_IDX);
    localparam logic [IMM_W-1:0] POS4  = IMM_W'(4);
    localparam logic [IMM_W-1:0] NEG4  = ~POS4 + 1'b1;

    uop_tpl_t            tpl;
    rsel_e               sel     [3];
    logic [REG_W-1:0]    reg_out [3];

    function automatic logic [REG_W-1:0] pick(rsel_e s, logic [REG_W-1:0] d,
                                              logic [REG_W-1:0] r, logic [REG_W-1:0] b);
        case (s)
            SEL_DST:  return d;
            SEL_SRC:  return r;
            SEL_BASE: return b;
            SEL_SP:   return SP_R;
            SEL_TMP:  return TMP_R;
            default:  return '0;
        endcase
    endfunction

    assign tpl    = uop_template(cls, 2'(step));
    assign sel[0] = tpl.dst;
    assign sel[1] = tpl.sa;
    assign sel[2] = tpl.sb;

    generate
        for (genvar g = 0; g < 3; g++) begin : g_slot
            assign reg_out[g] = pick(sel[g], dst_i, src_i, base_i);
        end
    endgenerate

    always_comb begin
        case (tpl.imm)
            IMM_DISP: imm_o = disp_i;
            IMM_IMM:  imm_o = imm_i;
            IMM_M4:   imm_o = NEG4;
            IMM_P4:   imm_o = POS4;
            default:  imm_o = '0;
        endcase
    end

    assign op_o  = tpl.op;
    assign fn_o  = tpl.use_fn ? fn_i : '0;
    assign dst_o = reg_out[0];
    assign sa_o  = reg_out[1];
    assign sb_o  = reg_out[2];

endmodule

// File: rtl/uc_cracker.sv
module uc_cracker
    import uc_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int IMM_W   = 16,
    parameter int FN_W    = 3,
    parameter int SP_IDX  = 14,
    parameter int TMP_IDX = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       in_cls,
    input  logic [FN_W-1:0]  in_fn,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src,
    input  logic [REG_W-1:0] in_base,
    input  logic [IMM_W-1:0] in_disp,
    input  logic [IMM_W-1:0] in_imm,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_op,
    output logic [FN_W-1:0]  out_fn,
    output logic [REG_W-1:0] out_dst,
    output logic [REG_W-1:0] out_srca,
    output logic [REG_W-1:0] out_srcb,
    output logic [IMM_W-1:0] out_imm,
    output logic             out_last
);
    localparam int STEP_W = $clog2(MAX_UOPS);

    logic [3:0]        cls_q;
    logic [FN_W-1:0]   fn_q;
    logic [REG_W-1:0]  dst_q, src_q, base_q;
    logic [IMM_W-1:0]  disp_q, imm_q;
    logic [STEP_W:0]   len_w;
    logic [STEP_W-1:0] step_w;
    logic              accept_w;

    assign len_w = (STEP_W+1)'(seq_len(cls_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q  <= '0;
            fn_q   <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            base_q <= '0;
            disp_q <= '0;
            imm_q  <= '0;
        end else if (accept_w) begin
            cls_q  <= in_cls;
            fn_q   <= in_fn;
            dst_q  <= in_dst;
            src_q  <= in_src;
            base_q <= in_base;
            disp_q <= in_disp;
            imm_q  <= in_imm;
        end
    end

    uc_step_ctrl #(.STEP_W(STEP_W)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .seq_len  (len_w),
        .busy     (out_valid),
        .step     (step_w),
        .last     (out_last),
        .in_ready (in_ready),
        .accept   (accept_w)
    );

    uc_uop_gen #(
        .REG_W  (REG_W),
        .IMM_W  (IMM_W),
        .FN_W   (FN_W),
        .SP_IDX (SP_IDX),
        .TMP_IDX(TMP_IDX),
        .STEP_W (STEP_W)
    ) i_gen (
        .cls   (cls_q),
        .step  (step_w),
        .fn_i  (fn_q),
        .dst_i (dst_q),
        .src_i (src_q),
        .base_i(base_q),
        .disp_i(disp_q),
        .imm_i (imm_q),
        .op_o  (out_op),
        .fn_o  (out_fn),
        .dst_o (out_dst),
        .sa_o  (out_srca),
        .sb_o  (out_srcb),
        .imm_o (out_imm)
    );

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_dst)
            && $stable(out_srca) && $stable(out_srcb) && $stable(out_imm)
            && $stable(out_fn) && $stable(out_last)); // R9

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R10

    AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last && !in_valid |=> !out_valid); // R12

    AST_NOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_op == UOP_NOP) |-> out_last); // R11

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && in_ready); // R1

endmodule

// File: tb/test_uc_cracker.sv
module test_uc_cracker;
    localparam time CLK_PERIOD = 10ns;
    localparam int  RW = 5;
    localparam int  IW = 16;
    localparam int  FW = 3;
    localparam logic [RW-1:0] SPR  = 5'd29;
    localparam logic [RW-1:0] TMPR = 5'd31;
    localparam logic [IW-1:0] M4   = 16'hFFFC;
    localparam logic [IW-1:0] P4   = 16'h0004;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, out_valid, out_ready, out_last;
    logic [3:0]    in_cls, out_op;
    logic [FW-1:0] in_fn, out_fn;
    logic [RW-1:0] in_dst, in_src, in_base, out_dst, out_srca, out_srcb;
    logic [IW-1:0] in_disp, in_imm, out_imm;

    always #(CLK_PERIOD/2) clk = ~clk;

    uc_cracker #(.REG_W(RW), .IMM_W(IW), .FN_W(FW), .SP_IDX(29), .TMP_IDX(31)) i_uc_cracker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_fn(in_fn), .in_dst(in_dst), .in_src(in_src),
        .in_base(in_base), .in_disp(in_disp), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_fn(out_fn), .out_dst(out_dst), .out_srca(out_srca),
        .out_srcb(out_srcb), .out_imm(out_imm), .out_last(out_last)
    );

    typedef struct {
        logic [3:0]    op;
        logic [FW-1:0] fn;
        logic [RW-1:0] d, a, b;
        logic [IW-1:0] imm;
        logic          last;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    bit   stalled = 1'b0;

    function automatic exp_t mk(logic [3:0] op, logic [FW-1:0] fn, logic [RW-1:0] d,
                                logic [RW-1:0] a, logic [RW-1:0] b, logic [IW-1:0] imm,
                                logic last, string tag);
        exp_t e;
        e.op = op; e.fn = fn; e.d = d; e.a = a; e.b = b; e.imm = imm; e.last = last; e.tag = tag;
        return e;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected expansion built from the requirement text.
    task automatic push_seq(logic [3:0] c, logic [FW-1:0] f, logic [RW-1:0] d,
                            logic [RW-1:0] s, logic [RW-1:0] bs,
                            logic [IW-1:0] dp, logic [IW-1:0] im);
        case (c)
            4'd0: q.push_back(mk(4'd1, f, d, d, s, '0, 1, "R2"));
            4'd1: q.push_back(mk(4'd2, '0, '0, d, s, '0, 1, "R2"));
            4'd2: q.push_back(mk(4'd3, f, '0, '0, '0, im, 1, "R2"));
            4'd3: q.push_back(mk(4'd4, '0, d, bs, '0, dp, 1, "R3"));
            4'd4: q.push_back(mk(4'd5, '0, '0, bs, s, dp, 1, "R3"));
            4'd5: begin
                q.push_back(mk(4'd4, '0, TMPR, bs, '0, dp, 0, "R4"));
                q.push_back(mk(4'd1, f, d, d, TMPR, '0, 1, "R4"));
            end
            4'd6: begin
                q.push_back(mk(4'd4, '0, TMPR, bs, '0, dp, 0, "R5"));
                q.push_back(mk(4'd1, f, TMPR, TMPR, s, '0, 0, "R5"));
                q.push_back(mk(4'd5, '0, '0, bs, TMPR, dp, 1, "R5"));
            end
            4'd7: begin
                q.push_back(mk(4'd7, '0, TMPR, '0, '0, '0, 0, "R6"));
                q.push_back(mk(4'd5, '0, '0, SPR, TMPR, M4, 0, "R6"));
                q.push_back(mk(4'd6, '0, SPR, SPR, '0, M4, 0, "R6"));
                q.push_back(mk(4'd8, '0, '0, '0, '0, im, 1, "R6"));
            end
            4'd8: begin
                q.push_back(mk(4'd6, '0, SPR, SPR, '0, P4, 0, "R7"));
                q.push_back(mk(4'd4, '0, TMPR, SPR, '0, M4, 0, "R7"));
                q.push_back(mk(4'd9, '0, '0, TMPR, '0, '0, 1, "R7"));
            end
            4'd9: begin
                q.push_back(mk(4'd5, '0, '0, SPR, s, M4, 0, "R8"));
                q.push_back(mk(4'd6, '0, SPR, SPR, '0, M4, 1, "R8"));
            end
            default: q.push_back(mk(4'd0, '0, '0, '0, '0, '0, 1, "R11"));
        endcase
    endtask

    // One cycle: drive at the falling edge, check, update the model.
    task automatic cyc(bit iv, bit ordy, logic [3:0] c);
        bit    exp_rdy;
        string tg;
        in_valid  = iv;
        out_ready = ordy;
        in_cls    = c;
        in_fn     = FW'($urandom);
        in_dst    = RW'($urandom_range(1, 20));
        in_src    = RW'($urandom_range(1, 20));
        in_base   = RW'($urandom_range(1, 20));
        in_disp   = IW'($urandom);
        in_imm    = IW'($urandom);
        #1;
        exp_rdy = (q.size() == 0) || (q.size() == 1 && ordy);
        chk(in_ready == exp_rdy, "R10", "in_ready", 64'(in_ready), 64'(exp_rdy));
        chk(out_valid == (q.size() != 0), "R10", "out_valid", 64'(out_valid), 64'(q.size() != 0));
        if (q.size() != 0 && out_valid) begin
            tg = stalled ? "R9" : q[0].tag;
            chk({out_op, out_fn, out_dst, out_srca, out_srcb, out_imm} ==
                {q[0].op, q[0].fn, q[0].d, q[0].a, q[0].b, q[0].imm}, tg, "uop",
                64'({out_op, out_fn, out_dst, out_srca, out_srcb, out_imm}),
                64'({q[0].op, q[0].fn, q[0].d, q[0].a, q[0].b, q[0].imm}));
            chk(out_last == q[0].last, "R12", "last", 64'(out_last), 64'(q[0].last));
        end
        stalled = (q.size() != 0) && !ordy;
        if (q.size() != 0 && ordy) void'(q.pop_front());
        if (iv && exp_rdy) push_seq(c, in_fn, in_dst, in_src, in_base, in_disp, in_imm);
        @(negedge clk);
    endtask

    task automatic drain(bit ordy_always);
        while (q.size() != 0) cyc(1'b0, ordy_always ? 1'b1 : 1'($urandom_range(0, 1)), 4'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_cls = '0; in_fn = '0;
        in_dst = '0; in_src = '0; in_base = '0; in_disp = '0; in_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", 64'(in_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);

        // Directed: every class, consumer always ready (R2..R8, R11).
        for (int c = 0; c < 16; c++) begin
            cyc(1'b1, 1'b1, 4'(c));
            drain(1'b1);
        end
        // Directed: call with stalls on every step (R9).
        cyc(1'b1, 1'b0, 4'd7);
        for (int k = 0; k < 4; k++) begin
            cyc(1'b0, 1'b0, 4'd0);
            cyc(1'b0, 1'b0, 4'd0);
            cyc(1'b0, 1'b1, 4'd0);
        end
        drain(1'b1);
        // Directed: back-to-back handover with no gap (R10).
        cyc(1'b1, 1'b1, 4'd9);
        cyc(1'b1, 1'b1, 4'd8);
        cyc(1'b1, 1'b1, 4'd1);
        cyc(1'b1, 1'b1, 4'd0);
        drain(1'b1);
        // Random mix.
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] rc;
            rc = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
            cyc(1'($urandom_range(0, 9) < 7), 1'($urandom_range(0, 9) < 6), rc);
        end
        drain(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule